// File: doc/BRIEF.md
# Address Window Register Unit

This unit holds the programmable address windows of a bus bridge and turns them into per-window decode results. There are six windows: a configuration window, a message window, three outbound windows and a register window. Each window has a 64-bit base and a mask. The unit occupies 23 consecutive words on a word-addressed 32-bit register bus, starting at the offset `UNIT_BASE`. Software programs the windows through plain register writes and can read every register back.

From each mask the unit derives an enable and a window size. Bit 0 of the mask switches the window on. The rest of the mask, with bit 0 cleared, is subtracted from two to the power of the mask width to give the size. The configuration window's size is capped at `CFG_MAX_SIZE`. One particular register-window mask value selects a fixed 4 KiB window. A 64-bit lookup address is compared against every window at once, which yields one hit bit per window.

The windows are numbered as follows: 0 configuration, 1 message, 2 to 4 outbound, 5 register. This numbering selects both the bit in `win_en` and `win_hit` and the 65-bit slice of `win_size`.

Top module: `addr_window_unit`

## Requirements
- R1: After reset every register reads 0, every `win_en` bit is 0 and no `win_hit` bit is set, whatever the lookup address.
- R2: The registers sit at fixed word offsets from `UNIT_BASE`. Each 64-bit quantity occupies two words, with its high half at the lower offset.
  - Configuration window: base 0/1, mask 2.
  - Message window: base 3/4, mask 5.
  - Outbound windows n = 0..2: base at 6+4n and 7+4n, mask at 8+4n (high half) and 9+4n (low half).
  - Register window: base 18/19, mask 20.
  - Two free-use words: 21 and 22.
  - Every register reads back exactly the last value written to it.
- R3: A write to one half of a 64-bit base or mask changes only that half; the other half keeps its value.
- R4: Accesses outside offsets 0..22 of the unit have no effect: reads return 0, writes change no register and no window output.
- R5: Bit 0 of a window's mask word is that window's enable; for an outbound window it is bit 0 of the low mask half.
- R6: Window size equals 2^W minus the mask with bit 0 cleared, where W is 32 for the configuration, message and register windows and 64 for outbound windows. It is computed without wrap, so a mask of 1 gives 2^W.
- R7: A configuration-window size above `CFG_MAX_SIZE` (default 2^28) is reported and decoded as `CFG_MAX_SIZE`.
- R8: A register-window mask equal to 0x00007001 gives a size of 4096; every other value follows R6.
- R9: `win_hit[w]` is 1 exactly when window w is enabled and the lookup address and the base are equal in all bits at or above log2 of the window size (all 64 bits are compared against the mask ~(size-1)).
- R10: Window enables and sizes change only after a register write inside the unit.
- R11: `UNIT_BASE` must be 0x100 or 0x120; any other value is rejected at elaboration, and an instance answers only at its own 23 offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Word address on the register bus |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational, 0 outside the unit |
| lk_addr | input | 2*DW | Address to decode against the windows |
| win_en | output | 6 | Per-window enable |
| win_size | output | 6*(2*DW+1) | Per-window size in bytes, 65 bits per window, window 0 in the lowest slice |
| win_hit | output | 6 | Per-window decode hit for `lk_addr` |

## Verification
The size logic is driven with every contiguous mask for each window, over all 32 or 64 power-of-two sizes and with the enable bit toggled. This shows whether the subtraction, the wide computation and the cap are applied to the right windows. Irregular masks and the masks next to the fixed register-window value separate the fixed-size match from the general rule. Hits are probed at the first and last byte of each window, one byte either side of it, and with a single flipped upper address bit. This exposes off-by-one and truncated compares. Writes to each half of every 64-bit field, and to addresses just outside the unit and at the other instance's offset, check that the register decode stays independent per word.

// File: rtl/awu_pkg.sv
package awu_pkg;

   // window numbering, shared by the hit, enable and size vectors
   localparam int unsigned NWIN     = 6;
   localparam int unsigned NREG     = 23;
   localparam int unsigned WIN_CFG  = 0;
   localparam int unsigned WIN_MSG  = 1;
   localparam int unsigned WIN_OUT0 = 2;
   localparam int unsigned WIN_OUT2 = 4;
   localparam int unsigned WIN_REG  = 5;

   // word offset of the high half of each window base
   function automatic int unsigned base_hi_idx(input int unsigned w);
      case (w)
         0:       return 0;
         1:       return 3;
         2:       return 6;
         3:       return 10;
         4:       return 14;
         default: return 18;
      endcase
   endfunction

   // word offset of the mask word holding the enable bit
   function automatic int unsigned mask_lo_idx(input int unsigned w);
      case (w)
         0:       return 2;
         1:       return 5;
         2:       return 9;
         3:       return 13;
         4:       return 17;
         default: return 20;
      endcase
   endfunction

   // high mask half, only meaningful for outbound windows
   function automatic int unsigned mask_hi_idx(input int unsigned w);
      return mask_lo_idx(w) - 1;
   endfunction

   function automatic bit is_wide(input int unsigned w);
      return (w >= WIN_OUT0) && (w <= WIN_OUT2);
   endfunction

endpackage

// File: rtl/awu_bus_decode.sv
module awu_bus_decode #(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned UNIT_BASE = 'h100,
   parameter int unsigned NREG      = 23,
   parameter int unsigned IDX_W     = 5
)(
   input  logic [ADDR_W-1:0] reg_addr,
   output logic              sel,
   output logic [IDX_W-1:0]  idx
);

   logic [ADDR_W-1:0] offs;

   assign offs = reg_addr - ADDR_W'(UNIT_BASE);
   assign sel  = (reg_addr >= ADDR_W'(UNIT_BASE)) && (offs < ADDR_W'(NREG));
   assign idx  = IDX_W'(offs);

endmodule

// File: rtl/awu_regfile.sv
module awu_regfile #(
   parameter int unsigned DW    = 32,
   parameter int unsigned NREG  = 23,
   parameter int unsigned IDX_W = 5
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   idx,
   input  logic [DW-1:0]      wr_data,
   output logic [DW-1:0]      rd_data,
   output logic [NREG*DW-1:0] words
);

   for (genvar i = 0; i < NREG; i++) begin : g_word
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (idx == IDX_W'(i)))
            q <= wr_data;
      end
      assign words[i*DW +: DW] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (idx == IDX_W'(i))
            rd_data = words[i*DW +: DW];
      end
   end

endmodule

// File: rtl/awu_window.sv
module awu_window #(
   parameter int unsigned     AW         = 64,
   parameter int unsigned     MASK_W     = 32,
   parameter bit              CLAMP_EN   = 1'b0,
   parameter longint unsigned CLAMP_MAX  = 64'h1000_0000,
   parameter bit              FIXED_EN   = 1'b0,
   parameter longint unsigned FIXED_MASK = 64'h7001,
   parameter longint unsigned FIXED_SIZE = 64'd4096
)(
   input  logic [AW-1:0]     base,
   input  logic [MASK_W-1:0] mask,
   input  logic [AW-1:0]     addr,
   output logic              en,
   output logic [AW:0]       size,
   output logic              hit
);

   localparam int unsigned SZ_W = AW + 1;

   logic [MASK_W-1:0] m_clr;
   logic [SZ_W-1:0]   span;
   logic [SZ_W-1:0]   raw;
   logic [SZ_W-1:0]   capped;
   logic [AW-1:0]     amask;

   assign en    = mask[0];
   assign m_clr = mask & ~MASK_W'(1);
   assign span  = SZ_W'(1) << MASK_W;
   assign raw   = span - SZ_W'(m_clr);

   if (CLAMP_EN) begin : g_clamp
      assign capped = (raw > SZ_W'(CLAMP_MAX)) ? SZ_W'(CLAMP_MAX) : raw;
   end else begin : g_noclamp
      assign capped = raw;
   end

   if (FIXED_EN) begin : g_fixed
      assign size = (mask == MASK_W'(FIXED_MASK)) ? SZ_W'(FIXED_SIZE) : capped;
   end else begin : g_nofixed
      assign size = capped;
   end

   // a size of 2^AW has zero low bits, so the mask below becomes all zero
   assign amask = ~(size[AW-1:0] - AW'(1));
   assign hit   = en && (((addr ^ base) & amask) == '0);

endmodule

// File: rtl/addr_window_unit.sv
module addr_window_unit
   import awu_pkg::*;
#(
   parameter int unsigned     DW             = 32,
   parameter int unsigned     ADDR_W         = 10,
   parameter int unsigned     UNIT_BASE      = 'h100,
   parameter longint unsigned CFG_MAX_SIZE   = 64'h1000_0000,
   parameter int unsigned     REG_FIXED_MASK = 'h7001,
   parameter longint unsigned REG_FIXED_SIZE = 64'd4096
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic                      reg_wr,
   input  logic [DW-1:0]             reg_wdata,
   output logic [DW-1:0]             reg_rdata,
   input  logic [2*DW-1:0]           lk_addr,
   output logic [NWIN-1:0]           win_en,
   output logic [NWIN*(2*DW+1)-1:0]  win_size,
   output logic [NWIN-1:0]           win_hit
);

   localparam int unsigned AW    = 2 * DW;
   localparam int unsigned SZ_W  = AW + 1;
   localparam int unsigned IDX_W = $clog2(NREG);

   // elaboration checks
   if (!((UNIT_BASE == 'h100) || (UNIT_BASE == 'h120))) begin : g_bad_base
      $error("addr_window_unit: UNIT_BASE must be 0x100 or 0x120");
   end
   if ((UNIT_BASE + NREG) > (1 << ADDR_W)) begin : g_bad_aw
      $error("addr_window_unit: ADDR_W too narrow for UNIT_BASE");
   end
   if (DW < 16) begin : g_bad_dw
      $error("addr_window_unit: DW must be at least 16");
   end
   if ((CFG_MAX_SIZE == 0) || ((CFG_MAX_SIZE & (CFG_MAX_SIZE - 1)) != 0)) begin : g_bad_cap
      $error("addr_window_unit: CFG_MAX_SIZE must be a power of two");
   end

   logic              sel;
   logic [IDX_W-1:0]  idx;
   logic [DW-1:0]     rf_rdata;
   logic [NREG*DW-1:0] words;

   awu_bus_decode #(
      .ADDR_W    (ADDR_W),
      .UNIT_BASE (UNIT_BASE),
      .NREG      (NREG),
      .IDX_W     (IDX_W)
   ) i_decode (
      .reg_addr (reg_addr),
      .sel      (sel),
      .idx      (idx)
   );

   awu_regfile #(
      .DW    (DW),
      .NREG  (NREG),
      .IDX_W (IDX_W)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && sel),
      .idx     (idx),
      .wr_data (reg_wdata),
      .rd_data (rf_rdata),
      .words   (words)
   );

   assign reg_rdata = sel ? rf_rdata : '0;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam bit          WIDE = is_wide(w);
      localparam int unsigned MW   = WIDE ? AW : DW;
      localparam int unsigned BHI  = base_hi_idx(w);
      localparam int unsigned MLO  = mask_lo_idx(w);

      logic [AW-1:0] base;
      logic [MW-1:0] mask;

      assign base = {words[BHI*DW +: DW], words[(BHI+1)*DW +: DW]};

      if (WIDE) begin : g_wide
         assign mask = {words[mask_hi_idx(w)*DW +: DW], words[MLO*DW +: DW]};
      end else begin : g_narrow
         assign mask = words[MLO*DW +: DW];
      end

      awu_window #(
         .AW         (AW),
         .MASK_W     (MW),
         .CLAMP_EN   (w == WIN_CFG),
         .CLAMP_MAX  (CFG_MAX_SIZE),
         .FIXED_EN   (w == WIN_REG),
         .FIXED_MASK (64'(REG_FIXED_MASK)),
         .FIXED_SIZE (REG_FIXED_SIZE)
      ) i_win (
         .base (base),
         .mask (mask),
         .addr (lk_addr),
         .en   (win_en[w]),
         .size (win_size[w*SZ_W +: SZ_W]),
         .hit  (win_hit[w])
      );
   end

endmodule

// File: rtl/awu_checker.sv
module awu_checker #(
   parameter int unsigned     DW           = 32,
   parameter int unsigned     ADDR_W       = 10,
   parameter int unsigned     UNIT_BASE    = 'h100,
   parameter longint unsigned CFG_MAX_SIZE = 64'h1000_0000
)(
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic                   reg_wr,
   input logic [DW-1:0]          reg_wdata,
   input logic [DW-1:0]          reg_rdata,
   input logic [5:0]             win_en,
   input logic [6*(2*DW+1)-1:0]  win_size,
   input logic [5:0]             win_hit
);

   localparam int unsigned SZ_W = 2 * DW + 1;
   localparam int unsigned NW   = 23;

   logic              in_rng;
   logic              last_vld;
   logic [ADDR_W-1:0] last_addr;
   logic [DW-1:0]     last_data;

   assign in_rng = ({1'b0, reg_addr} >= (ADDR_W+1)'(UNIT_BASE)) &&
                   ({1'b0, reg_addr} <  (ADDR_W+1)'(UNIT_BASE + NW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_vld  <= 1'b0;
         last_addr <= '0;
         last_data <= '0;
      end else if (reg_wr && in_rng) begin
         last_vld  <= 1'b1;
         last_addr <= reg_addr;
         last_data <= reg_wdata;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (win_en == '0) && (win_hit == '0) && (reg_rdata == '0)); // R1

   AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (last_vld && (reg_addr == last_addr)) |-> (reg_rdata == last_data)); // R2

   AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_rng |-> (reg_rdata == '0)); // R4

   AST_OUTSIDE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !in_rng) |=> ($stable(win_en) && $stable(win_size))); // R4

   AST_CFG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      win_size[SZ_W-1:0] <= SZ_W'(CFG_MAX_SIZE)); // R7

   AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit & ~win_en) == '0); // R9

   AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> ($stable(win_en) && $stable(win_size))); // R10

endmodule

bind addr_window_unit awu_checker #(
   .DW           (DW),
   .ADDR_W       (ADDR_W),
   .UNIT_BASE    (UNIT_BASE),
   .CFG_MAX_SIZE (CFG_MAX_SIZE)
) i_awu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .win_en    (win_en),
   .win_size  (win_size),
   .win_hit   (win_hit)
);

// File: tb/test_addr_window_unit.sv
module test_addr_window_unit;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned BASE       = 'h120;
   localparam int unsigned NREG       = 23;
   localparam int unsigned NWIN       = 6;
   localparam int unsigned SZ_W       = 65;
   localparam logic [64:0] CAP        = 65'h1000_0000;

   localparam int BHI [NWIN] = '{0, 3, 6, 10, 14, 18};
   localparam int MLO [NWIN] = '{2, 5, 9, 13, 17, 20};
   localparam int MHI [NWIN] = '{0, 0, 8, 12, 16, 0};

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [9:0]           reg_addr = '0;
   logic                 reg_wr = 1'b0;
   logic [31:0]          reg_wdata = '0;
   logic [31:0]          reg_rdata;
   logic [63:0]          lk_addr = '0;
   logic [NWIN-1:0]      win_en;
   logic [NWIN*SZ_W-1:0] win_size;
   logic [NWIN-1:0]      win_hit;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] shadow [NREG];

   addr_window_unit #(.UNIT_BASE(BASE)) i_addr_window_unit (
      .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .lk_addr (lk_addr),
      .win_en (win_en), .win_size (win_size), .win_hit (win_hit)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [64:0] act, input logic [64:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if ((int'(a) >= BASE) && (int'(a) < BASE + NREG)) shadow[int'(a) - BASE] = d;
   endtask

   task automatic wr_off(input int i, input logic [31:0] d);
      wr(10'(BASE + i), d);
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic verify_all(input string req);
      logic [31:0] v;
      for (int i = 0; i < NREG; i++) begin
         rd(10'(BASE + i), v);
         check(v === shadow[i], req, $sformatf("word %0d", i), 65'(v), 65'(shadow[i]));
      end
   endtask

   function automatic logic [64:0] exp_size(input int w);
      logic [63:0] m;
      logic [64:0] s;
      if (w >= 2 && w <= 4) begin
         m = {shadow[MHI[w]], shadow[MLO[w]]};
         s = (65'd1 << 64) - {1'b0, m & ~64'd1};
      end else begin
         m = {32'd0, shadow[MLO[w]]};
         s = (65'd1 << 32) - {1'b0, m & ~64'd1};
      end
      if (w == 0 && s > CAP) s = CAP;
      if (w == 5 && m[31:0] == 32'h7001) s = 65'd4096;
      return s;
   endfunction

   function automatic logic exp_hit(input int w, input logic [63:0] a);
      logic [64:0] s;
      logic [63:0] b;
      logic [63:0] am;
      s  = exp_size(w);
      b  = {shadow[BHI[w]], shadow[BHI[w] + 1]};
      am = ~(s[63:0] - 64'd1);
      return shadow[MLO[w]][0] && (((a ^ b) & am) == 64'd0);
   endfunction

   task automatic check_win(input int w, input string req);
      #1;
      check(win_en[w] === shadow[MLO[w]][0], req, $sformatf("enable win %0d", w),
            65'(win_en[w]), 65'(shadow[MLO[w]][0]));
      check(win_size[w*SZ_W +: SZ_W] === exp_size(w), req, $sformatf("size win %0d", w),
            win_size[w*SZ_W +: SZ_W], exp_size(w));
   endtask

   task automatic check_hits(input logic [63:0] a, input string req);
      logic [NWIN-1:0] e;
      lk_addr = a;
      #1;
      for (int w = 0; w < NWIN; w++) e[w] = exp_hit(w, a);
      check(win_hit === e, req, $sformatf("hits for %h", a), 65'(win_hit), 65'(e));
   endtask

   // program window w for a size of 2^k with the given enable bit
   task automatic program_size(input int w, input int k, input bit en);
      logic [64:0] s;
      logic [63:0] m;
      s = 65'd1 << k;
      m = ~(s[63:0] - 64'd1);
      m[0] = en;
      if (w >= 2 && w <= 4) wr_off(MHI[w], m[63:32]);
      wr_off(MLO[w], m[31:0]);
   endtask

   task automatic set_base(input int w, input logic [63:0] b);
      wr_off(BHI[w], b[63:32]);
      wr_off(BHI[w] + 1, b[31:0]);
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [NWIN*SZ_W-1:0] snap;
      logic [63:0] b;
      for (int i = 0; i < NREG; i++) shadow[i] = '0;

      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      verify_all("R1");
      #1 check(win_en === '0, "R1", "enables after reset", 65'(win_en), 65'd0);
      check_hits(64'd0, "R1");
      check_hits(64'hFFFF_FFFF_FFFF_FFFF, "R1");

      // R2: offsets and readback
      for (int i = 0; i < NREG; i++) wr_off(i, 32'h9E37_79B9 * (i + 1));
      verify_all("R2");
      for (int w = 0; w < NWIN; w++) check_win(w, "R2");

      // R3: half independence on every 64-bit field
      for (int w = 0; w < NWIN; w++) begin
         wr_off(BHI[w], 32'hC0DE_0000 + w);
         verify_all("R3");
         wr_off(BHI[w] + 1, 32'h0000_BEEF + w);
         verify_all("R3");
         if (w >= 2 && w <= 4) begin
            wr_off(MHI[w], 32'hFFFF_0000 + w);
            verify_all("R3");
            wr_off(MLO[w], 32'h1234_5671 + w);
            verify_all("R3");
         end
      end

      // R4 and R11: accesses outside the unit
      snap = win_size;
      wr(10'(BASE - 1), 32'hDEAD_0001);
      wr(10'(BASE + NREG), 32'hDEAD_0002);
      wr(10'h100, 32'hDEAD_0003);
      wr(10'h3FF, 32'hDEAD_0004);
      verify_all("R4");
      #1 check(win_size === snap, "R4", "sizes after outside writes", 65'(win_size == snap), 65'd1);
      rd(10'(BASE - 1), v);
      check(v === '0, "R4", "read below unit", 65'(v), 65'd0);
      rd(10'(BASE + NREG), v);
      check(v === '0, "R4", "read above unit", 65'(v), 65'd0);
      rd(10'h100, v);
      check(v === '0, "R11", "read at the other instance offset", 65'(v), 65'd0);

      // R5 R6 R7 R8: size sweeps over every contiguous mask
      for (int w = 0; w < NWIN; w++) begin
         int kmax;
         kmax = (w >= 2 && w <= 4) ? 64 : 32;
         for (int k = 1; k <= kmax; k++) begin
            program_size(w, k, k[0]);
            check_win(w, (w == 0) ? "R7" : "R6");
            check_win(w, "R5");
         end
      end
      wr_off(MLO[1], 32'h1234_5679);
      check_win(1, "R6");
      wr_off(MLO[5], 32'h0000_7001);
      check_win(5, "R8");
      wr_off(MLO[5], 32'h0000_7000);
      check_win(5, "R8");
      wr_off(MLO[5], 32'h0000_7003);
      check_win(5, "R8");
      wr_off(MLO[5], 32'h0001_7001);
      check_win(5, "R8");

      // R9: hit decode at window edges
      for (int w = 0; w < NWIN; w++) begin
         set_base(w, 64'h0000_00A0_0000_0000 + 64'(w) * 64'h1_0001_0000);
         program_size(w, 12, 1'b1);
      end
      for (int w = 0; w < NWIN; w++) begin
         b = 64'h0000_00A0_0000_0000 + 64'(w) * 64'h1_0001_0000;
         check_hits(b, "R9");
         check_hits(b + 64'hFFF, "R9");
         check_hits(b + 64'h1000, "R9");
         check_hits(b - 64'd1, "R9");
         check_hits(b ^ (64'd1 << 40), "R9");
      end
      program_size(3, 12, 1'b0);
      check_hits(64'h0000_00A0_0000_0000 + 64'h3_0003_0000, "R9");

      // R7: capped configuration window decodes at the cap
      set_base(0, 64'h0000_0040_0000_0000);
      wr_off(MLO[0], 32'hE000_0001);
      check_win(0, "R7");
      check_hits(64'h0000_0040_0FFF_FFFF, "R7");
      check_hits(64'h0000_0040_1000_0000, "R7");

      // R8: fixed register window decodes 4 KiB
      set_base(5, 64'h0000_0000_8000_0000);
      wr_off(MLO[5], 32'h0000_7001);
      check_hits(64'h0000_0000_8000_0FFF, "R8");
      check_hits(64'h0000_0000_8000_1000, "R8");

      // R6: full-range outbound window matches everything
      program_size(2, 64, 1'b1);
      check_win(2, "R6");
      check_hits(64'h5A5A_0000_1234_0000, "R6");

      // R10: no change without writes
      snap = win_size;
      repeat (5) @(negedge clk);
      #1 check(win_size === snap, "R10", "sizes while idle", 65'(win_size == snap), 65'd1);

      finish_run();
   end

endmodule